// File: doc/BRIEF.md
# Frame Writeback Control Registers

This block holds the software-visible setup for an engine that stores one display frame into memory, and sequences that frame one line at a time. Software programs a destination base, a line pitch and the frame size, then sets a start bit in the control word. The block raises a line request toward the pixel datapath and presents the memory address of the current line. It counts each line the datapath reports as committed, and goes idle when the programmed number of lines is reached or software aborts.

An interrupt level reports that the engine has gone idle after a frame. Software clears it by rewriting the control word with the enable bit at zero. Two further control bits are passed on to the rest of the engine. One requests a fresh frame start when a frame ends. The other powers down the engine's internal memory.

The register port is a plain single-cycle write strobe with a combinational read mux, addressed by byte offset.

Top module: `wbk_ctrl`

## Requirements
- R1: Offsets 0x00 (base), 0x04 (pitch) and 0x08 (size: height in bits 31:16, width in bits 15:0) read back the last 32-bit value written, are zero after reset, and unmapped offsets read zero.
- R2: Writing the control word at 0x0C with bit 0 set while idle starts a frame: from the next cycle bit 1 of the control word reads 1 (busy) and progress reads 0. Bit 0 always reads 0.
- R3: Control bits 31:22 always read 10'b0101010001 (0x54 then 2'b01). Bit 1 reflects only the busy state. Bits 21:15 and 13:2 read back as written. Bit 14 reads 0.
- R4: `lineReq` is high exactly while busy and progress is below the programmed height. `lineAddr` equals base + progress × pitch, truncated to LINE_ADDR_W bits.
- R5: Progress at 0x10 counts `lineDone` pulses seen while `lineReq` is high, one per pulse, visible the next cycle. Writes to 0x10 have no effect.
- R6: When busy and progress is not below the height, busy clears at the next clock edge. The done state is then recorded. A height of zero gives a frame that is busy for one cycle.
- R7: Writing the control word with bit 14 set while busy clears busy and `lineReq` on the next cycle. Progress is held, even when `lineDone` arrives in the same cycle. The done state is recorded. The bit has no effect while idle.
- R8: `irq` equals control bit 2 AND the done state AND NOT busy. The done state clears when a frame starts. Writing bit 2 as 0 drops `irq` in the next cycle.
- R9: A start written while busy is ignored: progress is not cleared and the frame continues.
- R10: `frameStart` pulses for one cycle in the cycle after a frame is started. It also pulses in the cycle after a frame ends normally, if control bit 15 is set. It does not pulse after an abort.
- R11: `memPowerDown` follows control bit 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| lineReq | output | 1 | A line of the frame is wanted |
| lineAddr | output | LINE_ADDR_W | Memory address of the requested line |
| lineDone | input | 1 | Datapath committed the requested line |
| frameStart | output | 1 | One-cycle frame-start request |
| irq | output | 1 | Idle interrupt level |
| memPowerDown | output | 1 | Internal memory power-down level |

## Verification
The bench builds the block with LINE_ADDR_W = 20. A base near the top of that range, combined with a large pitch, makes the line address wrap within a short frame, so truncation is observed directly. Heights of 0, 3 and 5 bring the zero-line frame, gaps between commits and GO or abort collisions within a few hundred cycles. The abort write is issued in the same cycle as a commit, which tests which of the two takes priority.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int REG_W = 32;
  localparam int BUS_AW = 5;
  localparam int CNT_W = 16;

  localparam logic [BUS_AW-1:0] OFS_BASE  = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_PITCH = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_SIZE  = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [BUS_AW-1:0] OFS_PROG  = 5'h10;

  localparam int BIT_START   = 0;
  localparam int BIT_IRQEN   = 2;
  localparam int BIT_ABORT   = 14;
  localparam int BIT_RESTART = 15;
  localparam int BIT_PWRDN   = 21;

  localparam logic [9:0] ID_BITS = 10'b0101010001;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h003F_BFFC;

  typedef struct packed {
    logic goWr;
    logic abortWr;
  } busCmd_t;

  typedef struct packed {
    logic clearCount;
    logic incCount;
  } seqStrobe_t;
endpackage

// File: rtl/wbk_regs.sv
module wbk_regs
  import wbk_pkg::*;
#(
  parameter int LINE_ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [BUS_AW-1:0]      busAddr,
  input  logic [REG_W-1:0]       busWrData,
  output logic [REG_W-1:0]       busRdData,
  input  logic                   busy,
  input  seqStrobe_t             strobe,
  output busCmd_t                cmd,
  output logic                   countBelow,
  output logic [LINE_ADDR_W-1:0] lineAddr,
  output logic                   restartEn,
  output logic                   irqEn,
  output logic                   pwrDown
);
  logic [REG_W-1:0] baseReg, pitchReg, sizeReg, ctrlReg;
  logic [CNT_W-1:0] lineCount;
  logic [REG_W-1:0] lineOffs, lineFull;
  logic             ctrlWr;

  assign ctrlWr = busWrEn && (busAddr == OFS_CTRL);
  assign cmd.goWr = ctrlWr && busWrData[BIT_START];
  assign cmd.abortWr = ctrlWr && busWrData[BIT_ABORT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      pitchReg <= '0;
      sizeReg  <= '0;
      ctrlReg  <= '0;
    end else if (busWrEn) begin
      case (busAddr)
        OFS_BASE:  baseReg  <= busWrData;
        OFS_PITCH: pitchReg <= busWrData;
        OFS_SIZE:  sizeReg  <= busWrData;
        OFS_CTRL:  ctrlReg  <= busWrData & CTRL_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lineCount <= '0;
    else if (strobe.clearCount) lineCount <= '0;
    else if (strobe.incCount) lineCount <= lineCount + 1'b1;
  end

  assign countBelow = lineCount < sizeReg[REG_W-1 -: CNT_W];
  assign lineOffs = pitchReg * {{(REG_W-CNT_W){1'b0}}, lineCount};
  assign lineFull = baseReg + lineOffs;
  assign lineAddr = lineFull[LINE_ADDR_W-1:0];
  assign restartEn = ctrlReg[BIT_RESTART];
  assign irqEn = ctrlReg[BIT_IRQEN];
  assign pwrDown = ctrlReg[BIT_PWRDN];

  always_comb begin
    case (busAddr)
      OFS_BASE:  busRdData = baseReg;
      OFS_PITCH: busRdData = pitchReg;
      OFS_SIZE:  busRdData = sizeReg;
      OFS_CTRL:  busRdData = {ID_BITS, ctrlReg[21:15], 1'b0, ctrlReg[13:2], busy, 1'b0};
      OFS_PROG:  busRdData = {{(REG_W-CNT_W){1'b0}}, lineCount};
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/wbk_seq.sv
module wbk_seq
  import wbk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busCmd_t    cmd,
  input  logic       countBelow,
  input  logic       restartEn,
  input  logic       lineDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       doneSeen,
  output logic       lineReq,
  output logic       frameStart
);
  logic startAcc, abortAcc, endNow;

  assign startAcc = cmd.goWr && !busy;
  assign abortAcc = cmd.abortWr && busy;
  assign endNow   = busy && !countBelow && !abortAcc;
  assign lineReq  = busy && countBelow;

  assign strobe.clearCount = startAcc;
  assign strobe.incCount   = lineReq && lineDone && !abortAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      doneSeen   <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= startAcc || (endNow && restartEn);
      if (abortAcc || endNow) begin
        busy     <= 1'b0;
        doneSeen <= 1'b1;
      end else if (startAcc) begin
        busy     <= 1'b1;
        doneSeen <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wbk_ctrl.sv
module wbk_ctrl
  import wbk_pkg::*;
#(
  parameter int LINE_ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic [4:0]             busAddr,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  output logic                   lineReq,
  output logic [LINE_ADDR_W-1:0] lineAddr,
  input  logic                   lineDone,
  output logic                   frameStart,
  output logic                   irq,
  output logic                   memPowerDown
);
  busCmd_t    cmd;
  seqStrobe_t strobe;
  logic       busy, doneSeen, countBelow, restartEn, irqEn;

  wbk_regs #(.LINE_ADDR_W(LINE_ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busy(busy),
    .strobe(strobe), .cmd(cmd), .countBelow(countBelow),
    .lineAddr(lineAddr), .restartEn(restartEn), .irqEn(irqEn),
    .pwrDown(memPowerDown)
  );

  wbk_seq i_seq (
    .clk(clk), .rstN(rstN), .cmd(cmd), .countBelow(countBelow),
    .restartEn(restartEn), .lineDone(lineDone), .strobe(strobe),
    .busy(busy), .doneSeen(doneSeen), .lineReq(lineReq),
    .frameStart(frameStart)
  );

  assign irq = irqEn && doneSeen && !busy;
endmodule

// File: rtl/wbk_ctrl_chk.sv
module wbk_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [4:0]  busAddr,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic        lineReq,
  input logic        irq,
  input logic        busy,
  input logic [15:0] progress
);
  logic ctrlWr, startAcc;
  assign ctrlWr   = busWrEn && (busAddr == 5'h0C);
  assign startAcc = ctrlWr && busWrData[0] && !busy;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startAcc |=> (busy && progress == 16'd0)); // R2
  AST_ID_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 5'h0C) |-> (busRdData[31:22] == 10'b0101010001)); // R3
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> busy); // R4
  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !startAcc |=> (progress == $past(progress) || progress == $past(progress) + 16'd1)); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWrData[14] && busy) |=> (!busy && !lineReq && $stable(progress))); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !irq); // R8
endmodule

bind wbk_ctrl wbk_ctrl_chk i_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .lineReq(lineReq),
  .irq(irq), .busy(busy), .progress(i_regs.lineCount)
);

// File: tb/test_wbk_ctrl.sv
`timescale 1ns/1ps
module test_wbk_ctrl;
  localparam int AW = 20;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, lineDone = 1'b0;
  logic [4:0] busAddr = 5'h0;
  logic [31:0] busWrData = '0, busRdData;
  logic lineReq, frameStart, irq, memPowerDown;
  logic [AW-1:0] lineAddr;
  int nRun = 0, nFail = 0, cycles = 0;

  always #2 clk = ~clk;

  wbk_ctrl #(.LINE_ADDR_W(AW)) i_wbk_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .lineReq(lineReq),
    .lineAddr(lineAddr), .lineDone(lineDone), .frameStart(frameStart),
    .irq(irq), .memPowerDown(memPowerDown)
  );

  // behavioural reference
  logic [31:0] mBase, mPitch, mSize, mCtrl;
  logic [15:0] mCnt;
  logic mBusy, mDone, mFs;

  always @(posedge clk) begin
    logic cw, st, ab, fs;
    if (!rstN) begin
      mBase = 0; mPitch = 0; mSize = 0; mCtrl = 0; mCnt = 0;
      mBusy = 0; mDone = 0; mFs = 0;
    end else begin
      cw = busWrEn && busAddr == 5'h0C;
      st = cw && busWrData[0] && !mBusy;
      ab = cw && busWrData[14] && mBusy;
      fs = 0;
      if (ab) begin mBusy = 0; mDone = 1; end
      else if (st) begin mBusy = 1; mCnt = 0; mDone = 0; fs = 1; end
      else if (mBusy && mCnt >= mSize[31:16]) begin mBusy = 0; mDone = 1; fs = mCtrl[15]; end
      else if (mBusy && lineDone) mCnt = mCnt + 1;
      mFs = fs;
      if (busWrEn) begin
        if (busAddr == 5'h00) mBase = busWrData;
        if (busAddr == 5'h04) mPitch = busWrData;
        if (busAddr == 5'h08) mSize = busWrData;
        if (busAddr == 5'h0C) mCtrl = busWrData & 32'h003F_BFFC;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRd(input logic [4:0] a);
    case (a)
      5'h00: return mBase;
      5'h04: return mPitch;
      5'h08: return mSize;
      5'h0C: return {10'b0101010001, mCtrl[21:15], 1'b0, mCtrl[13:2], mBusy, 1'b0};
      5'h10: return {16'h0, mCnt};
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    logic [31:0] ea;
    if (rstN) begin
      ea = (mBase + mPitch * {16'h0, mCnt}) & 32'h000F_FFFF;
      chk(lineReq === (mBusy && mCnt < mSize[31:16]), "R4 lineReq", {31'h0, lineReq}, {31'h0, mBusy && mCnt < mSize[31:16]});
      if (lineReq) chk(lineAddr === ea[AW-1:0], "R4 lineAddr", {12'h0, lineAddr}, ea);
      chk(irq === (mCtrl[2] && mDone && !mBusy), "R8 irq", {31'h0, irq}, {31'h0, mCtrl[2] && mDone && !mBusy});
      chk(frameStart === mFs, "R10 frameStart", {31'h0, frameStart}, {31'h0, mFs});
      chk(memPowerDown === mCtrl[21], "R11 memPowerDown", {31'h0, memPowerDown}, {31'h0, mCtrl[21]});
      if (busAddr == 5'h10) chk(busRdData === expRd(busAddr), "R5 progress", busRdData, expRd(busAddr));
      else if (busAddr == 5'h0C) chk(busRdData === expRd(busAddr), "R2 R3 control", busRdData, expRd(busAddr));
      else chk(busRdData === expRd(busAddr), "R1 register", busRdData, expRd(busAddr));
    end
  end

  task automatic cyc(input bit we, input logic [4:0] a, input logic [31:0] d, input bit ld);
    @(negedge clk); #1;
    busWrEn = we; busAddr = a; busWrData = d; lineDone = ld;
    @(posedge clk); #1;
    busWrEn = 0; lineDone = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    cyc(0, a, 0, 0);
    @(negedge clk); v = busRdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 5'h10, 0, 0);
  endtask

  task automatic runLines(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 5'h10, 0, 1);
      cyc(0, 5'h10, 0, 0);
    end
  endtask

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    rd(5'h00, v); chk(v == 0, "R1 reset base", v, 0);
    rd(5'h0C, v); chk(v == 32'h5440_0000, "R3 reset control", v, 32'h5440_0000);
    rd(5'h14, v); chk(v == 0, "R1 unmapped", v, 0);
    cyc(1, 5'h00, 32'h0000_1000, 0);
    cyc(1, 5'h04, 32'h0000_0040, 0);
    cyc(1, 5'h08, {16'd3, 16'd8}, 0);
    rd(5'h08, v); chk(v == {16'd3, 16'd8}, "R1 size", v, {16'd3, 16'd8});
    cyc(1, 5'h10, 32'h0000_00FF, 0);
    rd(5'h10, v); chk(v == 0, "R5 progress read-only", v, 0);
    // frame with irq enabled
    cyc(1, 5'h0C, 32'h0000_0005, 0);
    rd(5'h0C, v); chk(v[1] == 1'b1 && v[0] == 1'b0, "R2 busy after start", v, 32'h5440_0006);
    runLines(2);
    cyc(1, 5'h0C, 32'h0000_0005, 0);
    rd(5'h10, v); chk(v == 2, "R9 start while busy ignored", v, 2);
    cyc(0, 5'h10, 0, 1);
    idle(3);
    rd(5'h0C, v); chk(v[1] == 1'b0, "R6 idle after last line", v, 32'h5440_0004);
    chk(irq == 1'b1, "R8 irq after frame", {31'h0, irq}, 1);
    cyc(1, 5'h0C, 32'h0000_0000, 0);
    idle(1);
    chk(irq == 1'b0, "R8 irq acknowledged", {31'h0, irq}, 0);
    // restart request at end of frame
    cyc(1, 5'h0C, 32'h0000_8005, 0);
    runLines(3);
    idle(3);
    // abort with a commit in the same cycle
    cyc(1, 5'h0C, 32'h0000_8005, 0);
    runLines(1);
    cyc(1, 5'h0C, 32'h0000_C004, 1);
    rd(5'h10, v); chk(v == 1, "R7 progress held on abort", v, 1);
    rd(5'h0C, v); chk(v[1] == 1'b0 && v[14] == 1'b0, "R7 idle after abort", v, 32'h5440_8004);
    cyc(1, 5'h0C, 32'h0000_4004, 0);
    rd(5'h10, v); chk(v == 1, "R7 abort while idle no effect", v, 1);
    // zero-height frame
    cyc(1, 5'h08, {16'd0, 16'd8}, 0);
    cyc(1, 5'h0C, 32'h0000_0005, 0);
    idle(3);
    chk(irq == 1'b1, "R6 zero-height frame done", {31'h0, irq}, 1);
    // address wrap at 20 bits
    cyc(1, 5'h00, 32'h000F_FF00, 0);
    cyc(1, 5'h04, 32'h0000_0080, 0);
    cyc(1, 5'h08, {16'd5, 16'd8}, 0);
    cyc(1, 5'h0C, 32'h0000_0001, 0);
    runLines(5);
    idle(3);
    // all writable control bits, power-down
    cyc(1, 5'h0C, 32'hFFFF_FFFE, 0);
    rd(5'h0C, v); chk(v == 32'h547F_BFFC, "R3 control readback", v, 32'h547F_BFFC);
    chk(memPowerDown == 1'b1, "R11 power-down set", {31'h0, memPowerDown}, 1);
    cyc(1, 5'h0C, 32'h0000_0000, 0);
    idle(2);
    finishRun();
  end
endmodule